// File: doc/BRIEF.md
# Synchronous SRAM write-cycle controller

This block is the control front end of a pipelined synchronous static memory. On every rising clock edge it samples two address strobes (one driven by a processor, one by a memory controller), a three-wire chip-select group, a global write, a byte-write enable with one select per byte lane, a burst-advance input and an output enable. All of these inputs are active-low except the middle chip select. From them it decides whether the cycle starts an access, and whether that access writes. It loads the address register and a two-bit burst offset. It issues a per-lane write mask to a behavioural lane-sliced memory array.

It also produces the enable for the output drivers of the shared data bus. That enable is taken away whenever the write inputs request a write, whatever the output-enable input says. Write data can therefore be placed on the bus without a driver fight. Reads are reduced to a combinational look-up at the current burst address, which lets the effect of every write be seen at the ports.

Top module: `ssram_wr_ctrl`

## Requirements
- R1: A write happens on a rising edge only when `ctl_strb_n` is 0, `cpu_strb_n` is 1, the chip-select group is active and the write mask is non-zero. It completes at that single edge, so after that edge `rdata` at the written address shows the new data.
- R2: The chip-select group is active only for `ce_a_n`=0, `ce_b`=1, `ce_c_n`=0. Every other combination suppresses the write and leaves `cur_addr` unchanged.
- R3: With `all_wr_n`=0, all four lanes are written, whatever `lane_wr_n` and `lane_sel_n` are.
- R4: With `all_wr_n`=1 and `lane_wr_n`=0, lane i (data bits 8i+7..8i) is written when `lane_sel_n[i]`=0. Every other lane keeps its old content.
- R5: With `all_wr_n`=1 and either `lane_wr_n`=1 or `lane_sel_n`=4'b1111, the cycle is not a write and memory is not modified.
- R6: With `cpu_strb_n`=0 and the group active, the cycle starts a read. The write inputs are ignored, memory is unchanged and the address is loaded.
- R7: `drv_en` is combinational. It is 1 exactly when `oe_n`=0 and no write is requested, where a request means `all_wr_n`=0, or `lane_wr_n`=0 with some `lane_sel_n` bit at 0.
- R8: An access start (either strobe at 0 with the group active) loads `addr` so that `cur_addr` equals it after the edge, and `step_n` is ignored in that cycle.
- R9: With both strobes at 1 and `step_n`=0, the two-bit burst offset advances. With the linear variant (default) the low address bits are base+offset mod 4; the upper bits never change. With `step_n`=1 and no start, `cur_addr` holds.
- R10: Asynchronous reset (`rst_n`=0) clears `cur_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strb_n | input | 1 | Processor-side address strobe, active-low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active-low |
| ce_a_n | input | 1 | Chip select A, active-low |
| ce_b | input | 1 | Chip select B, active-high |
| ce_c_n | input | 1 | Chip select C, active-low |
| all_wr_n | input | 1 | Global write, active-low |
| lane_wr_n | input | 1 | Byte-write enable, active-low |
| lane_sel_n | input | LANES | Per-lane write selects, active-low |
| oe_n | input | 1 | Output enable, active-low |
| step_n | input | 1 | Burst advance, active-low |
| addr | input | ADDR_W | Access address |
| wdata | input | LANES*LANE_W | Write data from the shared bus |
| rdata | output | LANES*LANE_W | Array content at `cur_addr` |
| cur_addr | output | ADDR_W | Registered burst address |
| drv_en | output | 1 | Data-bus output-driver enable, active-high |

## Verification
The hardest situation to reach from the ports is a cycle that looks like a write but must not write. Examples are both strobes low, one chip select wrong, or the byte-write enable active with no lane selected. In each of these cases a wrong write would only show up later as corrupted content. The bench first fills the whole array with known full-word writes. It then applies each near-miss vector and reads the same address back through a processor-strobe access, so that any stray lane update appears on `rdata`. The burst wrap is reached by starting at an address whose low bits are 2 while holding `step_n` low during the start cycle. This checks both that the start cycle ignores the advance input and that the offset wraps back to 0.

// File: rtl/ssram_wr_pkg.sv
package ssram_wr_pkg;
   typedef enum logic {
      BURST_LINEAR      = 1'b0,
      BURST_INTERLEAVED = 1'b1
   } burst_e;

   localparam int BURST_BITS = 2;
endpackage

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode #(
   parameter int LANES = 4
) (
   input  logic             cpu_strb_n,
   input  logic             ctl_strb_n,
   input  logic             ce_a_n,
   input  logic             ce_b,
   input  logic             ce_c_n,
   input  logic             all_wr_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             oe_n,
   input  logic             step_n,
   output logic             start,
   output logic             advance,
   output logic             wr_en,
   output logic [LANES-1:0] wr_mask,
   output logic             drv_en
);
   logic             chip_on;
   logic [LANES-1:0] req_mask;
   logic             wr_req;

   always_comb begin
      chip_on = ~ce_a_n & ce_b & ~ce_c_n;
      if (!all_wr_n)       req_mask = '1;
      else if (!lane_wr_n) req_mask = ~lane_sel_n;
      else                 req_mask = '0;
      wr_req  = |req_mask;
      start   = chip_on & (~cpu_strb_n | ~ctl_strb_n);
      wr_en   = chip_on & ~ctl_strb_n & cpu_strb_n & wr_req;
      wr_mask = wr_en ? req_mask : '0;
      advance = cpu_strb_n & ctl_strb_n & ~step_n;
      drv_en  = ~oe_n & ~wr_req;
   end
endmodule

// File: rtl/ssram_burst_addr.sv
module ssram_burst_addr
   import ssram_wr_pkg::*;
#(
   parameter int     ADDR_W = 6,
   parameter burst_e MODE   = BURST_LINEAR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              advance,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] ofs_q;
   logic [BURST_BITS-1:0] lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ofs_q  <= '0;
      end else if (start) begin
         base_q <= addr_in;
         ofs_q  <= '0;
      end else if (advance) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   generate
      if (MODE == BURST_LINEAR) begin : g_linear
         assign lo = base_q[BURST_BITS-1:0] + ofs_q;
      end else begin : g_interleaved
         assign lo = base_q[BURST_BITS-1:0] ^ ofs_q;
      end
   endgenerate

   assign cur_addr = {base_q[ADDR_W-1 -: HI_W], lo};
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_mask[g]) lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
         end

         assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/ssram_wr_ctrl.sv
module ssram_wr_ctrl
   import ssram_wr_pkg::*;
#(
   parameter int     ADDR_W = 6,
   parameter int     LANES  = 4,
   parameter int     LANE_W = 8,
   parameter burst_e MODE   = BURST_LINEAR
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_strb_n,
   input  logic                    ctl_strb_n,
   input  logic                    ce_a_n,
   input  logic                    ce_b,
   input  logic                    ce_c_n,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    oe_n,
   input  logic                    step_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic [ADDR_W-1:0]       cur_addr,
   output logic                    drv_en
);
   localparam int DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W <= BURST_BITS || LANES < 1 || LANE_W < 1) begin : g_bad_cfg
         $error("ssram_wr_ctrl: ADDR_W must exceed the burst bits, LANES and LANE_W must be positive");
      end
   endgenerate

   logic             start;
   logic             advance;
   logic             wr_en;
   logic [LANES-1:0] wr_mask;

   ssram_wr_decode #(.LANES(LANES)) dec_i (
      .cpu_strb_n (cpu_strb_n),
      .ctl_strb_n (ctl_strb_n),
      .ce_a_n     (ce_a_n),
      .ce_b       (ce_b),
      .ce_c_n     (ce_c_n),
      .all_wr_n   (all_wr_n),
      .lane_wr_n  (lane_wr_n),
      .lane_sel_n (lane_sel_n),
      .oe_n       (oe_n),
      .step_n     (step_n),
      .start      (start),
      .advance    (advance),
      .wr_en      (wr_en),
      .wr_mask    (wr_mask),
      .drv_en     (drv_en)
   );

   ssram_burst_addr #(.ADDR_W(ADDR_W), .MODE(MODE)) bst_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .advance  (advance),
      .addr_in  (addr),
      .cur_addr (cur_addr)
   );

   ssram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
      .clk     (clk),
      .wr_mask (wr_mask),
      .wr_addr (addr),
      .wr_data (wdata[DATA_W-1:0]),
      .rd_addr (cur_addr),
      .rd_data (rdata)
   );
endmodule

// File: rtl/ssram_wr_ctrl_chk.sv
module ssram_wr_ctrl_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_strb_n,
   input logic              ctl_strb_n,
   input logic              ce_a_n,
   input logic              ce_b,
   input logic              ce_c_n,
   input logic              all_wr_n,
   input logic              step_n,
   input logic [ADDR_W-1:0] addr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              drv_en,
   input logic              wr_en
);
   logic grp_ok;
   logic any_strb;
   assign grp_ok   = !ce_a_n && ce_b && !ce_c_n;
   assign any_strb = !cpu_strb_n || !ctl_strb_n;

   p_deselect_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_ok |-> !wr_en);

   p_cpu_strobe_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_strb_n |-> !wr_en);

   p_global_write_drivers_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !all_wr_n |-> !drv_en);

   p_start_loads_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ok && any_strb) |=> (cur_addr == $past(addr)));

   p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((!any_strb && step_n) || (!grp_ok && any_strb)) |=> $stable(cur_addr));

   p_upper_bits_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strb && !step_n) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));
endmodule

bind ssram_wr_ctrl ssram_wr_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ssram_wr_ctrl_tb.sv
`timescale 1ns/1ps
module ssram_wr_ctrl_tb_top;
   localparam int ADDR_W = 6;
   localparam int LANES  = 4;
   localparam int LANE_W = 8;
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NV     = 12;

   // fields: cpu_n ctl_n | ce_a_n ce_b ce_c_n | all_n lane_en_n | lanes_n[3:0] | oe_n | addr[5:0] | exp drv_en
   localparam logic [18:0] VEC [NV] = '{
      19'b1_0_010_0_1_1111_0_000101_0,   // 0 global write, oe low
      19'b1_0_010_1_0_1010_0_001001_0,   // 1 lanes 0 and 2
      19'b1_0_010_0_0_0000_1_001010_0,   // 2 global wins over lane selects
      19'b1_0_010_1_0_1111_0_001100_1,   // 3 lane enable, no lane selected
      19'b1_0_010_1_1_0000_0_001101_1,   // 4 lane enable off
      19'b1_0_110_0_1_1111_1_001110_0,   // 5 ce_a_n high
      19'b1_0_000_0_1_1111_1_001111_0,   // 6 ce_b low
      19'b1_0_011_0_1_1111_1_010000_0,   // 7 ce_c_n high
      19'b0_0_010_0_1_1111_1_010001_0,   // 8 processor strobe also low
      19'b1_1_010_0_1_1111_1_010010_0,   // 9 no strobe
      19'b1_0_010_1_0_0111_0_010100_0,   // 10 lane 3 only
      19'b1_1_010_1_1_1111_0_010101_1    // 11 idle, oe low
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cpu_strb_n, ctl_strb_n, ce_a_n, ce_b, ce_c_n;
   logic              all_wr_n, lane_wr_n, oe_n, step_n;
   logic [LANES-1:0]  lane_sel_n;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;
   logic [ADDR_W-1:0] cur_addr;
   logic              drv_en;

   int                checks = 0;
   int                fails  = 0;
   logic [DATA_W-1:0] model [DEPTH];

   always #2.5 clk = ~clk;

   ssram_wr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .all_wr_n(all_wr_n),
      .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .oe_n(oe_n), .step_n(step_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cur_addr(cur_addr), .drv_en(drv_en)
   );

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_strb_n = 1'b1; ctl_strb_n = 1'b1;
      ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
      all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = '1;
      oe_n = 1'b1; step_n = 1'b1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic read_back(input logic [ADDR_W-1:0] a, input string req);
      idle();
      cpu_strb_n = 1'b0;
      addr = a;
      tick();
      idle();
      #1;
      chk(req, rdata, model[a]);
   endtask

   function automatic string vec_tag(input int i);
      case (i)
         0, 2:       return "R3";
         1, 10:      return "R4";
         3, 4:       return "R5";
         5, 6, 7:    return "R2";
         8:          return "R6";
         default:    return "R1";
      endcase
   endfunction

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      idle();
      addr = '0; wdata = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 reset address", DATA_W'(cur_addr), '0);
      chk("R7 drivers off with oe_n high", DATA_W'(drv_en), '0);
      rst_n = 1'b1;
      tick();

      // preload whole array with full-word controller writes
      for (int a = 0; a < DEPTH; a++) begin
         idle();
         ctl_strb_n = 1'b0; all_wr_n = 1'b0;
         addr = ADDR_W'(a);
         wdata = (DATA_W'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96;
         model[a] = wdata;
         tick();
      end
      idle();
      read_back(6'd7, "R1 preload");

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [18:0]      v;
         logic             sel;
         logic [LANES-1:0] m;
         v = VEC[i];
         idle();
         cpu_strb_n = v[18]; ctl_strb_n = v[17];
         ce_a_n = v[16]; ce_b = v[15]; ce_c_n = v[14];
         all_wr_n = v[13]; lane_wr_n = v[12]; lane_sel_n = v[11:8];
         oe_n = v[7]; addr = v[6:1];
         wdata = 32'h10203040 + DATA_W'(i) * 32'h0305_0709;
         #1;
         chk($sformatf("R7 drv_en vector %0d", i), DATA_W'(drv_en), DATA_W'(v[0]));
         sel = !v[16] && v[15] && !v[14];
         m = !v[13] ? '1 : (!v[12] ? ~v[11:8] : '0);
         if (sel && !v[17] && v[18] && (m != '0)) begin
            for (int l = 0; l < LANES; l++)
               if (m[l]) model[v[6:1]][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
         end
         tick();
         read_back(v[6:1], $sformatf("%s memory vector %0d", vec_tag(i), i));
      end

      // R2: deselected strobe leaves address register alone
      read_back(6'd40, "R6 read loads address");
      idle(); ce_b = 1'b0; cpu_strb_n = 1'b0; addr = 6'd3;
      tick(); idle(); #1;
      chk("R2 deselected start holds address", DATA_W'(cur_addr), DATA_W'(6'd40));

      // R8 + R1: controller write start with step_n low, single-edge completion
      idle(); ctl_strb_n = 1'b0; all_wr_n = 1'b0; step_n = 1'b0;
      addr = 6'd33; wdata = 32'hCAFE_F00D; model[33] = wdata;
      tick(); idle(); #1;
      chk("R8 start ignores advance", DATA_W'(cur_addr), DATA_W'(6'd33));
      chk("R1 write visible after one edge", rdata, 32'hCAFE_F00D);

      // R9: linear burst wrap from low bits 2
      idle(); cpu_strb_n = 1'b0; step_n = 1'b0; addr = 6'd6;
      tick(); idle(); #1;
      chk("R8 read start ignores advance", DATA_W'(cur_addr), DATA_W'(6'd6));
      step_n = 1'b0; tick(); #1;
      chk("R9 burst step 1", DATA_W'(cur_addr), DATA_W'(6'd7));
      tick(); #1;
      chk("R9 burst wrap", DATA_W'(cur_addr), DATA_W'(6'd4));
      chk("R9 burst data", rdata, model[4]);
      tick(); #1;
      chk("R9 burst step 3", DATA_W'(cur_addr), DATA_W'(6'd5));
      step_n = 1'b1; tick(); tick(); #1;
      chk("R9 hold without advance", DATA_W'(cur_addr), DATA_W'(6'd5));

      // R10: reset in mid-run
      rst_n = 1'b0; #1;
      chk("R10 async reset clears address", DATA_W'(cur_addr), '0);
      tick(); rst_n = 1'b1; tick();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule